// File: doc/BRIEF.md
# Fractional Clock Divider Bank with Triangular Spread

This block takes one fast synthesis clock and produces several slower output clocks, one per channel. Each channel divides by a ratio made of an integer part plus a numerator/denominator fraction. Every output period is either N or N+1 input cycles long; a fractional accumulator picks which one, so the long-run average period equals N + num/den exactly, with no drift.

Each channel may also sweep its ratio with a digital triangle to spread the output spectrum. Down-spread only lengthens periods. Center-spread first shortens the nominal ratio by half the sweep depth and then applies the same sweep, so the frequency swings on both sides of nominal. A start-up phase delay shifts a channel against the others, but only when that channel is not spreading. A per-channel inversion lets two channels with the same ratio form a complementary pair. A global spread-off input stops all spreading.

Top module: `fdiv_spread_bank`

## Requirements
- R1: While `rst_n` is low, or on the cycle after a channel's enable is sampled low, that channel's output is 0. Disabling clears the channel's accumulator and sweep, so the next enable starts afresh.
- R2: A period of length L starts with `(L/2)` (rounded down) high cycles, followed by `L - L/2` low cycles. L is N+1 when `acc + inc >= den`, and N otherwise. The accumulator then becomes `acc + inc - den` or `acc + inc`, and starts at 0.
- R3: With spread off, any `den` consecutive periods from enable total exactly `N*den + num` input cycles. Example: N=4, 1/4 gives lengths 4,4,4,5 (17 cycles).
- R4: The integer, fraction, spread and inversion inputs are sampled only on the cycle that starts a new period. A change in the middle of a period leaves that period's length and shape unchanged.
- R5: When enable is first sampled high at edge k, with spread inactive, the first period starts at edge k+1+P, where P is the channel's phase delay. The output is therefore first high after edge k+1+P.
- R6: When spread is active at the moment of enable, the phase delay is ignored and the first period starts at edge k+1.
- R7: With inversion set, the output is the bitwise complement of the same channel's waveform without inversion.
- R8: In down-spread, `inc = num + s`, where s is the current sweep level.
- R9: In center-spread (the center flag is 1), `inc = num - floor(amt/2) + s`.
- R10: The sweep level starts at 0 and steps once per period start: up by 1 until it reaches `amt`, then down by 1 until it reaches 0, then up again. The level used by a period is the one held before its step. With amt=4 the levels are 0,1,2,3,4,3,2,1,0,...
- R11: With `spread_off` high, every channel behaves as if its spread enable were 0: `inc = num`, the sweep level is held at 0, and the phase delay applies.
- R12: Channels are independent. Each one follows only its own slice of the configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast synthesis clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_off | input | 1 | Global spread disable |
| chan_en | input | NCH | Per-channel run enable |
| div_int | input | NCH*W_INT | Integer ratio N per channel (N >= 2) |
| frac_num | input | NCH*W_FRAC | Fraction numerator per channel |
| frac_den | input | NCH*W_FRAC | Fraction denominator per channel |
| phase_dly | input | NCH*W_PH | Start delay in input cycles per channel |
| out_inv | input | NCH | Invert the output waveform |
| sprd_en | input | NCH | Spread enable per channel |
| sprd_center | input | NCH | 1 = center-spread, 0 = down-spread |
| sprd_amt | input | NCH*W_FRAC | Sweep depth in fraction units |
| clk_out | output | NCH | Divided clocks |

## Verification
The run-length assertions assume that N is at least 2 and that every increment stays below the denominator. For down-spread this means `num + amt < den`. For center-spread it means `floor(amt/2) <= num` and `num - floor(amt/2) + amt < den`. These assumptions keep every period at N or N+1 cycles. Every configuration the stimulus applies is chosen to meet them. Each configuration change is made on a falling edge, so a change in the middle of a period is seen at a known cycle.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;
   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_WAIT = 2'd1,
      CH_RUN  = 2'd2
   } ch_state_e;
endpackage

// File: rtl/fdiv_frac_acc.sv
`timescale 1ns/1ps
module fdiv_frac_acc #(
   parameter int W_FRAC = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [W_FRAC:0]   inc,
   input  logic [W_FRAC-1:0] den,
   output logic              carry
);
   localparam int W_SUM = W_FRAC + 2;

   logic [W_FRAC-1:0] acc_q;
   logic [W_SUM-1:0]  sum;
   logic [W_SUM-1:0]  wrapped;

   always_comb begin
      sum     = {2'b00, acc_q} + {1'b0, inc};
      carry   = (sum >= {2'b00, den});
      wrapped = sum - {2'b00, den};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clr)   acc_q <= '0;
      else if (step)  acc_q <= carry ? wrapped[W_FRAC-1:0] : sum[W_FRAC-1:0];
   end
endmodule

// File: rtl/fdiv_tri_mod.sv
`timescale 1ns/1ps
module fdiv_tri_mod #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] amt,
   output logic [W-1:0] lvl_o
);
   logic [W-1:0] lvl_q;
   logic         up_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         up_q  <= 1'b1;
      end else if (clr) begin
         lvl_q <= '0;
         up_q  <= 1'b1;
      end else if (step) begin
         if (up_q) begin
            if (lvl_q < amt) lvl_q <= lvl_q + 1'b1;
            else begin
               up_q  <= 1'b0;
               lvl_q <= (lvl_q == '0) ? '0 : lvl_q - 1'b1;
            end
         end else begin
            if (lvl_q == '0) begin
               up_q  <= 1'b1;
               lvl_q <= (amt != '0) ? {{(W-1){1'b0}}, 1'b1} : '0;
            end else lvl_q <= lvl_q - 1'b1;
         end
      end
   end

   assign lvl_o = lvl_q;
endmodule

// File: rtl/fdiv_channel.sv
`timescale 1ns/1ps
module fdiv_channel
   import fdiv_pkg::*;
#(
   parameter int W_INT      = 8,
   parameter int W_FRAC     = 10,
   parameter int W_PH       = 6,
   parameter bit HAS_CENTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [W_INT-1:0]  div_int,
   input  logic [W_FRAC-1:0] num,
   input  logic [W_FRAC-1:0] den,
   input  logic [W_PH-1:0]   ph,
   input  logic              inv,
   input  logic              sp_on,
   input  logic              sp_center,
   input  logic [W_FRAC-1:0] sp_amt,
   output logic              clk_o
);
   localparam int W_LEN = W_INT + 1;

   if (W_INT < 2)  begin : g_bad_int  $error("W_INT must be at least 2");  end
   if (W_FRAC < 2) begin : g_bad_frac $error("W_FRAC must be at least 2"); end
   if (W_PH < 1)   begin : g_bad_ph   $error("W_PH must be at least 1");   end

   ch_state_e         st_q, st_n;
   logic [W_PH-1:0]   wcnt_q, wcnt_n;
   logic [W_LEN-1:0]  pos_q, pos_n, len_q, len_n;
   logic              inv_q, inv_n, out_q, out_n;
   logic              start, carry;
   logic [W_FRAC-1:0] lvl;
   logic [W_FRAC:0]   inc;

   if (HAS_CENTER) begin : g_center
      always_comb begin
         if (!sp_on)         inc = {1'b0, num};
         else if (sp_center) inc = {1'b0, num} - {1'b0, sp_amt >> 1} + {1'b0, lvl};
         else                inc = {1'b0, num} + {1'b0, lvl};
      end
   end else begin : g_down_only
      always_comb inc = sp_on ? ({1'b0, num} + {1'b0, lvl}) : {1'b0, num};
   end

   fdiv_frac_acc #(.W_FRAC(W_FRAC)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(!en), .step(start),
      .inc(inc), .den(den), .carry(carry)
   );

   fdiv_tri_mod #(.W(W_FRAC)) u_tri (
      .clk(clk), .rst_n(rst_n), .clr(!en || !sp_on), .step(start),
      .amt(sp_amt), .lvl_o(lvl)
   );

   always_comb begin
      st_n   = st_q;
      wcnt_n = wcnt_q;
      pos_n  = pos_q;
      len_n  = len_q;
      inv_n  = inv_q;
      start  = 1'b0;
      case (st_q)
         CH_IDLE: if (en) begin
            st_n   = CH_WAIT;
            wcnt_n = sp_on ? '0 : ph;
         end
         CH_WAIT: if (wcnt_q == '0) start = 1'b1;
                  else wcnt_n = wcnt_q - 1'b1;
         default: if (pos_q == len_q - 1'b1) start = 1'b1;
                  else pos_n = pos_q + 1'b1;
      endcase
      if (start) begin
         st_n  = CH_RUN;
         pos_n = '0;
         len_n = {1'b0, div_int} + {{(W_LEN-1){1'b0}}, carry};
         inv_n = inv;
      end
      if (!en) begin
         st_n  = CH_IDLE;
         start = 1'b0;
      end
      out_n = en && (st_n == CH_RUN) && ((pos_n < (len_n >> 1)) ^ inv_n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CH_IDLE;
         wcnt_q <= '0;
         pos_q  <= '0;
         len_q  <= '0;
         inv_q  <= 1'b0;
         out_q  <= 1'b0;
      end else begin
         st_q   <= st_n;
         wcnt_q <= wcnt_n;
         pos_q  <= pos_n;
         len_q  <= len_n;
         inv_q  <= inv_n;
         out_q  <= out_n;
      end
   end

   assign clk_o = out_q;
endmodule

// File: rtl/fdiv_spread_bank.sv
`timescale 1ns/1ps
module fdiv_spread_bank #(
   parameter int NCH    = 4,
   parameter int W_INT  = 8,
   parameter int W_FRAC = 10,
   parameter int W_PH   = 6
) (
   input  logic                  clk_vco,
   input  logic                  rst_n,
   input  logic                  spread_off,
   input  logic [NCH-1:0]        chan_en,
   input  logic [NCH*W_INT-1:0]  div_int,
   input  logic [NCH*W_FRAC-1:0] frac_num,
   input  logic [NCH*W_FRAC-1:0] frac_den,
   input  logic [NCH*W_PH-1:0]   phase_dly,
   input  logic [NCH-1:0]        out_inv,
   input  logic [NCH-1:0]        sprd_en,
   input  logic [NCH-1:0]        sprd_center,
   input  logic [NCH*W_FRAC-1:0] sprd_amt,
   output logic [NCH-1:0]        clk_out
);
   if (NCH < 1) begin : g_bad_nch $error("NCH must be at least 1"); end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      fdiv_channel #(
         .W_INT(W_INT), .W_FRAC(W_FRAC), .W_PH(W_PH), .HAS_CENTER(1'b1)
      ) u_ch (
         .clk       (clk_vco),
         .rst_n     (rst_n),
         .en        (chan_en[c]),
         .div_int   (div_int[c*W_INT +: W_INT]),
         .num       (frac_num[c*W_FRAC +: W_FRAC]),
         .den       (frac_den[c*W_FRAC +: W_FRAC]),
         .ph        (phase_dly[c*W_PH +: W_PH]),
         .inv       (out_inv[c]),
         .sp_on     (sprd_en[c] & ~spread_off),
         .sp_center (sprd_center[c]),
         .sp_amt    (sprd_amt[c*W_FRAC +: W_FRAC]),
         .clk_o     (clk_out[c])
      );
   end
endmodule

// File: rtl/fdiv_spread_chk.sv
`timescale 1ns/1ps
module fdiv_spread_chk #(
   parameter int NCH   = 4,
   parameter int W_INT = 8,
   parameter int W_PH  = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] en,
   input logic [NCH-1:0] out
);
   localparam int HI_MAX = 2 ** W_INT;
   localparam int LO_MAX = 2 ** W_PH + 2 ** W_INT + 2;
   localparam int CW     = $clog2(LO_MAX + 1) + 1;
   localparam logic [CW-1:0] SAT = {CW{1'b1}};

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_low: assert (out == '0)
            else $error("clock output active during reset");
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_mon
      logic [CW-1:0] hi_run, lo_run;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
         end else begin
            hi_run <= (!en[c] || !out[c]) ? '0 : ((hi_run == SAT) ? SAT : hi_run + 1'b1);
            lo_run <= (!en[c] ||  out[c]) ? '0 : ((lo_run == SAT) ? SAT : lo_run + 1'b1);
         end
      end

      // R1: a disabled channel is low on the next cycle
      a_r1_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
         !en[c] |=> !out[c]);

      // R5: the output can only rise after two enabled cycles
      a_r5_rise_after_en: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(out[c]) |-> ($past(en[c]) && $past(en[c], 2)));

      // R2: a high stretch never exceeds the longest possible period
      a_r2_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
         hi_run <= CW'(HI_MAX));

      // R2: a low stretch stays within delay plus one period
      a_r2_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
         lo_run <= CW'(LO_MAX));
   end
endmodule

bind fdiv_spread_bank fdiv_spread_chk #(
   .NCH(NCH), .W_INT(W_INT), .W_PH(W_PH)
) u_chk (
   .clk(clk_vco), .rst_n(rst_n), .en(chan_en), .out(clk_out)
);

// File: tb/sim_fdiv_spread_bank.sv
`timescale 1ns/1ps
module sim_fdiv_spread_bank;
   localparam int NCH = 4;
   localparam int WI  = 8;
   localparam int WF  = 10;
   localparam int WP  = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              spread_off;
   logic [NCH-1:0]    chan_en, out_inv, sprd_en, sprd_center;
   logic [NCH*WI-1:0] div_int;
   logic [NCH*WF-1:0] frac_num, frac_den, sprd_amt;
   logic [NCH*WP-1:0] phase_dly;
   logic [NCH-1:0]    clk_out;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   fdiv_spread_bank #(.NCH(NCH), .W_INT(WI), .W_FRAC(WF), .W_PH(WP)) u0 (
      .clk_vco(clk), .rst_n(rst_n), .spread_off(spread_off), .chan_en(chan_en),
      .div_int(div_int), .frac_num(frac_num), .frac_den(frac_den),
      .phase_dly(phase_dly), .out_inv(out_inv), .sprd_en(sprd_en),
      .sprd_center(sprd_center), .sprd_amt(sprd_amt), .clk_out(clk_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference, one entry per channel
   int  m_st[NCH], m_w[NCH], m_pos[NCH], m_len[NCH], m_acc[NCH], m_lvl[NCH];
   bit  m_up[NCH], m_inv[NCH], m_out[NCH];

   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         int  n_i, nu, de, ph, am, inc, s;
         bit  en, spon, st;
         n_i  = int'(div_int[c*WI +: WI]);
         nu   = int'(frac_num[c*WF +: WF]);
         de   = int'(frac_den[c*WF +: WF]);
         ph   = int'(phase_dly[c*WP +: WP]);
         am   = int'(sprd_amt[c*WF +: WF]);
         en   = chan_en[c];
         spon = sprd_en[c] && !spread_off;
         if (!rst_n) begin
            m_st[c] = 0; m_w[c] = 0; m_pos[c] = 0; m_len[c] = 0; m_acc[c] = 0;
            m_lvl[c] = 0; m_up[c] = 1; m_inv[c] = 0; m_out[c] = 0;
         end else begin
            st = 0;
            if (en) begin
               if (m_st[c] == 0) begin m_st[c] = 1; m_w[c] = spon ? 0 : ph; end
               else if (m_st[c] == 1) begin
                  if (m_w[c] == 0) st = 1; else m_w[c]--;
               end else begin
                  if (m_pos[c] == m_len[c] - 1) st = 1; else m_pos[c]++;
               end
            end
            if (st) begin
               inc = !spon ? nu : (sprd_center[c] ? nu - am / 2 + m_lvl[c] : nu + m_lvl[c]);
               s = m_acc[c] + inc;
               if (s >= de) begin m_len[c] = n_i + 1; m_acc[c] = s - de; end
               else begin m_len[c] = n_i; m_acc[c] = s; end
               m_pos[c] = 0; m_st[c] = 2; m_inv[c] = out_inv[c];
            end
            if (!en || !spon) begin m_lvl[c] = 0; m_up[c] = 1; end
            else if (st) begin
               if (m_up[c]) begin
                  if (m_lvl[c] < am) m_lvl[c]++;
                  else begin m_up[c] = 0; if (m_lvl[c] > 0) m_lvl[c]--; end
               end else begin
                  if (m_lvl[c] == 0) begin m_up[c] = 1; m_lvl[c] = (am != 0) ? 1 : 0; end
                  else m_lvl[c]--;
               end
            end
            if (!en) begin m_st[c] = 0; m_acc[c] = 0; end
            m_out[c] = en && (m_st[c] == 2) && ((m_pos[c] < m_len[c] / 2) ^ m_inv[c]);
         end
      end
      #1;
      for (int c = 0; c < NCH; c++)
         chk(clk_out[c] === m_out[c], cur_req, int'(clk_out[c]), int'(m_out[c]));
   end

   task automatic cfg(input int c, input int n_i, input int nu, input int de, input int ph,
                      input bit inv, input bit spe, input bit ctr, input int am);
      div_int[c*WI +: WI]   = WI'(n_i);
      frac_num[c*WF +: WF]  = WF'(nu);
      frac_den[c*WF +: WF]  = WF'(de);
      phase_dly[c*WP +: WP] = WP'(ph);
      out_inv[c]     = inv;
      sprd_en[c]     = spe;
      sprd_center[c] = ctr;
      sprd_amt[c*WF +: WF] = WF'(am);
   endtask

   task automatic wait_rise(input int c, output int cyc);
      bit p;
      cyc = 0;
      do begin
         p = clk_out[c];
         @(posedge clk); #1;
         cyc++;
      end while (!(p == 1'b0 && clk_out[c] == 1'b1) && cyc < 1000);
   endtask

   task automatic restart(input bit [NCH-1:0] mask);
      @(negedge clk); chan_en = '0;
      @(negedge clk); chan_en = mask;
   endtask

   initial begin
      int t, sum;
      int exp_dn[8] = '{4, 4, 4, 4, 5, 4, 4, 5};
      int exp_ct[8] = '{4, 4, 5, 4, 5, 5, 4, 5};
      int exp_fr[4] = '{4, 4, 4, 5};
      rst_n = 1'b0; spread_off = 1'b0; chan_en = '0;
      for (int c = 0; c < NCH; c++) cfg(c, 4, 0, 1, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      chk(clk_out == '0, "R1 reset", int'(clk_out), 0);
      rst_n = 1'b1;

      // R2 / R3: fraction 1/4
      cur_req = "R2";
      cfg(0, 4, 1, 4, 0, 0, 0, 0, 0);
      restart(4'b0001);
      wait_rise(0, t);
      chk(t == 2, "R5 first rise", t, 2);
      sum = 0;
      for (int i = 0; i < 4; i++) begin
         wait_rise(0, t); sum += t;
         chk(t == exp_fr[i], "R2 period", t, exp_fr[i]);
      end
      chk(sum == 17, "R3 average", sum, 17);

      // R4: mid-period change waits for the boundary
      cur_req = "R4";
      cfg(0, 10, 0, 1, 0, 0, 0, 0, 0);
      restart(4'b0001);
      wait_rise(0, t);
      @(negedge clk); cfg(0, 6, 0, 1, 0, 0, 0, 0, 0);
      wait_rise(0, t); chk(t == 10, "R4 old length kept", t, 10);
      wait_rise(0, t); chk(t == 6, "R4 new length", t, 6);

      // R1: disable mid-run
      cur_req = "R1";
      @(negedge clk); chan_en = '0;
      @(posedge clk); #1;
      chk(clk_out[0] == 1'b0, "R1 disabled low", int'(clk_out[0]), 0);

      // R5 / R6 / R7: phase delay, spread blocks it, inversion
      cur_req = "R5";
      cfg(0, 6, 0, 1, 0, 0, 0, 0, 0);
      cfg(1, 6, 0, 1, 3, 0, 0, 0, 0);
      cfg(2, 6, 0, 8, 5, 0, 1, 0, 2);
      cfg(3, 6, 0, 1, 0, 1, 0, 0, 0);
      begin
         int f0, f1, f2, mism;
         f0 = -1; f1 = -1; f2 = -1; mism = 0;
         @(negedge clk); chan_en = 4'b1111;
         for (int k = 1; k <= 40; k++) begin
            @(posedge clk); #1;
            if (f0 < 0 && clk_out[0]) f0 = k;
            if (f1 < 0 && clk_out[1]) f1 = k;
            if (f2 < 0 && clk_out[2]) f2 = k;
            if (k >= 2 && clk_out[3] !== ~clk_out[0]) mism++;
         end
         chk(f0 == 2, "R5 zero delay", f0, 2);
         chk(f1 == 5, "R5 delay of 3", f1, 5);
         chk(f2 == 2, "R6 delay ignored under spread", f2, 2);
         chk(mism == 0, "R7 complement pair", mism, 0);
      end

      // R12: independent ratios
      cur_req = "R12";
      cfg(0, 4, 0, 1, 0, 0, 0, 0, 0);
      cfg(1, 7, 0, 1, 0, 0, 0, 0, 0);
      restart(4'b0011);
      wait_rise(0, t); wait_rise(0, t); chk(t == 4, "R12 channel 0", t, 4);
      wait_rise(1, t); wait_rise(1, t); chk(t == 7, "R12 channel 1", t, 7);

      // R8 / R10: down-spread, depth 4
      cur_req = "R8";
      cfg(0, 4, 0, 8, 0, 0, 1, 0, 4);
      restart(4'b0001);
      wait_rise(0, t); sum = 0;
      for (int i = 0; i < 8; i++) begin
         wait_rise(0, t); sum += t;
         chk(t == exp_dn[i], "R10 sweep period", t, exp_dn[i]);
      end
      chk(sum == 34, "R8 down-spread total", sum, 34);

      // R9: center-spread
      cur_req = "R9";
      cfg(0, 4, 4, 8, 0, 0, 1, 1, 4);
      restart(4'b0001);
      wait_rise(0, t); sum = 0;
      for (int i = 0; i < 8; i++) begin
         wait_rise(0, t); sum += t;
         chk(t == exp_ct[i], "R9 center period", t, exp_ct[i]);
      end
      chk(sum == 36, "R9 center total", sum, 36);

      // R11: global spread off
      cur_req = "R11";
      @(negedge clk); spread_off = 1'b1;
      cfg(0, 4, 0, 8, 0, 0, 1, 0, 4);
      restart(4'b0001);
      wait_rise(0, t); sum = 0;
      for (int i = 0; i < 8; i++) begin wait_rise(0, t); sum += t; end
      chk(sum == 32, "R11 spread forced off", sum, 32);

      @(negedge clk); chan_en = '0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule